// File: doc/BRIEF.md
# Burst-Read Frame DMA Engine

This block fetches image frames from external memory and hands them, word by word, to a pair of downstream line buffers that feed a display pipeline. Software programs the number of frames, the image size in bytes and a burst length through a small register port, then writes a start bit. The engine then acts as a bus read master on a 32-bit data path. It issues burst reads with a burst count, holds each request while the memory side stalls with a wait signal, and forwards every word that the memory marks valid.

Frames are read from byte address 0 up to the image size. The address then wraps back to 0 for the next frame, until the programmed frame count is reached. Delivered words are steered to line buffer 0 or line buffer 1, changing buffer after every display row of `ROW_WORDS` words (320 words, 1280 bytes, by default). The display can then drain one row while the next one fills. Back-pressure comes in as a free-space count per line buffer. A burst is only issued when the buffer it targets can take the whole burst, so the word stream (`pix_valid` with no ready) never has to stall. Only one burst is outstanding at a time, so each free-space count needs to cover just that one burst. When the last word of the last frame arrives, a done flag is set and the engine goes idle.

Top module: `frame_burst_dma`

## Requirements
- R1: After reset, `mem_read` and `pix_valid` are 0, status reads 0, the frame count and image size read 0, and the burst length reads `BURST_MAX` (4).
- R2: Register offsets are 1 = frame count, 2 = image size in bytes, 3 = burst length, 4 = status (bit 0 done, bit 1 busy), 0 = control. Writing 1 to bit 0 of offset 0 starts a run, and reading offset 0 returns busy in bit 0. Written configuration values read back unchanged.
- R3: A write to offset 3 takes effect only if the value is a power of two between 1 and `BURST_MAX`; any other value leaves the old length. `mem_burstcount` always carries a legal length.
- R4: A start is ignored while busy, when the frame count is 0, or when the image size is smaller than one burst in bytes.
- R5: While `mem_read` is high and `mem_waitrequest` is high, `mem_read`, `mem_address` and `mem_burstcount` stay unchanged. A request is accepted in a cycle where both `mem_read` is high and `mem_waitrequest` is low, and `mem_read` is low in the next cycle.
- R6: Within a frame, burst addresses start at byte address 0 and step by 4 × burst length bytes. After the burst that reaches the image size, the address returns to 0 and the next frame begins, for as many frames as programmed.
- R7: No new read is issued until every beat of the outstanding burst has returned.
- R8: A burst is issued only when the free-space count of its target line buffer is at least the burst length (equal is enough).
- R9: Each word returned with `mem_readdatavalid` during a burst appears exactly once on `pix_data` with `pix_valid`, one cycle later and in order. A `mem_readdatavalid` pulse while no burst is outstanding produces nothing.
- R10: `pix_lane` is 0 for the first `ROW_WORDS` words after a start and then toggles after every further `ROW_WORDS` words.
- R11: After the last beat of the last burst, done is 1, busy is 0 and no further read is issued. An accepted start clears done.
- R12: Writes to the frame count, image size and burst length are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 3 | Register word offset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| mem_address | output | ADDR_W | Byte address of the current burst |
| mem_read | output | 1 | Read request, active high |
| mem_burstcount | output | BCW | Beats in the current burst |
| mem_waitrequest | input | 1 | Memory stall, active high |
| mem_readdata | input | DATA_W | Returned read word |
| mem_readdatavalid | input | 1 | Qualifies `mem_readdata` |
| lane0_room | input | ROOM_W | Free words in line buffer 0 |
| lane1_room | input | ROOM_W | Free words in line buffer 1 |
| pix_valid | output | 1 | A word is presented on `pix_data` |
| pix_data | output | DATA_W | Forwarded image word |
| pix_lane | output | 1 | Target line buffer of the word |

## Verification
The memory model in the bench stalls with waitrequest both in a long opening window and in a repeating pattern, and it leaves gaps between returned beats. This catches a design that moves its address or drops its request before acceptance, or one that counts gap cycles as beats. Runs cover burst lengths of 1, 2 and 4, multi-frame wrap and a row change of line buffer, so an off-by-one in the wrap compare or the row counter shows up as a wrong burst address or a word on the wrong lane. A phase where the next line buffer reports one word less than a burst, and then exactly a burst, exposes an engine that ignores free space or compares it the wrong way. A stray valid pulse while idle, and register writes during a run, show whether ignored inputs leak into the output stream or the configuration.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_REQ   = 2'd2,
    ST_BEATS = 2'd3
  } eng_state_t;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_FRAMES = 3'd1;
  localparam logic [2:0] OFS_SIZE   = 3'd2;
  localparam logic [2:0] OFS_BURST  = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;

endpackage

// File: rtl/fbd_regs.sv
module fbd_regs
  import fbd_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int SIZE_W    = 24,
  parameter int BURST_MAX = 4,
  parameter int BCW       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_addr,
  input  logic               cfg_wr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               busy,
  input  logic               done_set,
  output logic               start_go,
  output logic [FRAME_W-1:0] frames,
  output logic [SIZE_W-1:0]  size,
  output logic [BCW-1:0]     burst
);

  function automatic logic burst_legal(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0) && (v <= 32'(BURST_MAX));
  endfunction

  logic [FRAME_W-1:0] frames_q;
  logic [SIZE_W-1:0]  size_q;
  logic [BCW-1:0]     burst_q;
  logic               done_q;
  logic               size_fits;

  assign size_fits = ({1'b0, size_q} >= (SIZE_W+1)'({burst_q, 2'b00}));
  assign start_go  = cfg_wr && (cfg_addr == OFS_CTRL) && cfg_wdata[0] &&
                     !busy && (frames_q != '0) && size_fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames_q <= '0;
      size_q   <= '0;
      burst_q  <= BCW'(BURST_MAX);
      done_q   <= 1'b0;
    end else begin
      if (cfg_wr && !busy) begin
        case (cfg_addr)
          OFS_FRAMES: frames_q <= cfg_wdata[FRAME_W-1:0];
          OFS_SIZE:   size_q   <= cfg_wdata[SIZE_W-1:0];
          OFS_BURST:  if (burst_legal(cfg_wdata)) burst_q <= BCW'(cfg_wdata);
          default: ;
        endcase
      end
      if (start_go)      done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_CTRL:   cfg_rdata = {31'd0, busy};
      OFS_FRAMES: cfg_rdata = 32'(frames_q);
      OFS_SIZE:   cfg_rdata = 32'(size_q);
      OFS_BURST:  cfg_rdata = 32'(burst_q);
      OFS_STATUS: cfg_rdata = {30'd0, busy, done_q};
      default:    cfg_rdata = 32'd0;
    endcase
  end

  assign frames = frames_q;
  assign size   = size_q;
  assign burst  = burst_q;

  // R11: done and busy never both set
  assert_done_excl_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy));

  // R12: configuration frozen for a run
  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(frames_q) && $stable(size_q) && $stable(burst_q)));

endmodule

// File: rtl/fbd_addr_gen.sv
module fbd_addr_gen #(
  parameter int FRAME_W = 16,
  parameter int SIZE_W  = 24,
  parameter int BCW     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_go,
  input  logic               accept,
  input  logic [FRAME_W-1:0] frames,
  input  logic [SIZE_W-1:0]  size,
  input  logic [BCW-1:0]     burst,
  output logic [SIZE_W-1:0]  addr,
  output logic               last_burst
);

  logic [SIZE_W-1:0]  addr_q;
  logic [FRAME_W-1:0] frame_q;
  logic [SIZE_W:0]    step;
  logic [SIZE_W:0]    nxt;
  logic               wrap;

  assign step       = (SIZE_W+1)'({burst, 2'b00});
  assign nxt        = {1'b0, addr_q} + step;
  assign wrap       = (nxt >= {1'b0, size});
  assign last_burst = wrap && (frame_q == (frames - FRAME_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      frame_q <= '0;
    end else if (start_go) begin
      addr_q  <= '0;
      frame_q <= '0;
    end else if (accept) begin
      if (wrap) begin
        addr_q  <= '0;
        frame_q <= frame_q + FRAME_W'(1);
      end else begin
        addr_q  <= nxt[SIZE_W-1:0];
      end
    end
  end

  assign addr = addr_q;

  // R6: accepted bursts start inside the image on a word boundary
  assert_addr_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((addr_q < size) && (addr_q[1:0] == 2'b00)));

endmodule

// File: rtl/fbd_read_ctrl.sv
module fbd_read_ctrl
  import fbd_pkg::*;
#(
  parameter int BCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_go,
  input  logic           room_ok,
  input  logic           last_burst,
  input  logic [BCW-1:0] burst,
  input  logic           mem_waitrequest,
  input  logic           mem_readdatavalid,
  output logic           mem_read,
  output logic           busy,
  output logic           accept,
  output logic           beat_en,
  output logic           done_set
);

  eng_state_t     state_q;
  logic [BCW-1:0] left_q;
  logic           fin_q;
  logic           last_beat;

  assign mem_read  = (state_q == ST_REQ);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = mem_read && !mem_waitrequest;
  assign beat_en   = (state_q == ST_BEATS) && mem_readdatavalid;
  assign last_beat = beat_en && (left_q == BCW'(1));
  assign done_set  = last_beat && fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      fin_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_go) state_q <= ST_CHECK;
        ST_CHECK: if (room_ok)  state_q <= ST_REQ;
        ST_REQ: begin
          if (accept) begin
            left_q  <= burst;
            fin_q   <= last_burst;
            state_q <= ST_BEATS;
          end
        end
        ST_BEATS: begin
          if (beat_en) begin
            left_q <= left_q - BCW'(1);
            if (last_beat) state_q <= fin_q ? ST_IDLE : ST_CHECK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: a read only rises after free space was confirmed
  assert_room_before_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_read) |-> $past(room_ok));

  // R5: request withdrawn right after acceptance
  assert_drop_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_read);

  // R11: engine idles after the final beat
  assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> (!busy && !mem_read));

endmodule

// File: rtl/fbd_lane_steer.sv
module fbd_lane_steer #(
  parameter int DATA_W    = 32,
  parameter int ROW_WORDS = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              beat_en,
  input  logic [DATA_W-1:0] beat_data,
  output logic              cur_lane,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_lane
);

  localparam int RCW = $clog2(ROW_WORDS + 1);

  logic [RCW-1:0] row_cnt_q;
  logic           lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cnt_q <= '0;
      lane_q    <= 1'b0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_lane  <= 1'b0;
    end else begin
      pix_valid <= beat_en;
      if (start_go) begin
        row_cnt_q <= '0;
        lane_q    <= 1'b0;
      end else if (beat_en) begin
        pix_data <= beat_data;
        pix_lane <= lane_q;
        if (row_cnt_q == RCW'(ROW_WORDS - 1)) begin
          row_cnt_q <= '0;
          lane_q    <= !lane_q;
        end else begin
          row_cnt_q <= row_cnt_q + RCW'(1);
        end
      end
    end
  end

  assign cur_lane = lane_q;

  // R10: lane only changes when a row completes
  assert_lane_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_go && !beat_en) |=> $stable(lane_q));

endmodule

// File: rtl/frame_burst_dma.sv
module frame_burst_dma #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int FRAME_W   = 16,
  parameter int SIZE_W    = 24,
  parameter int BURST_MAX = 4,
  parameter int ROW_WORDS = 320,
  parameter int ROOM_W    = 12,
  localparam int BCW      = $clog2(BURST_MAX) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_addr,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [ADDR_W-1:0] mem_address,
  output logic              mem_read,
  output logic [BCW-1:0]    mem_burstcount,
  input  logic              mem_waitrequest,
  input  logic [DATA_W-1:0] mem_readdata,
  input  logic              mem_readdatavalid,
  input  logic [ROOM_W-1:0] lane0_room,
  input  logic [ROOM_W-1:0] lane1_room,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_lane
);

  logic               start_go, busy, accept, beat_en, done_set;
  logic               last_burst, room_ok, cur_lane;
  logic [FRAME_W-1:0] frames;
  logic [SIZE_W-1:0]  size;
  logic [SIZE_W-1:0]  addr;
  logic [BCW-1:0]     burst;
  logic [ROOM_W-1:0]  room_sel;

  fbd_regs #(.FRAME_W(FRAME_W), .SIZE_W(SIZE_W), .BURST_MAX(BURST_MAX), .BCW(BCW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .busy(busy), .done_set(done_set), .start_go(start_go),
    .frames(frames), .size(size), .burst(burst)
  );

  fbd_addr_gen #(.FRAME_W(FRAME_W), .SIZE_W(SIZE_W), .BCW(BCW)) agen_i (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .accept(accept), .frames(frames),
    .size(size), .burst(burst), .addr(addr), .last_burst(last_burst)
  );

  assign room_sel = cur_lane ? lane1_room : lane0_room;
  assign room_ok  = (room_sel >= ROOM_W'(burst));

  fbd_read_ctrl #(.BCW(BCW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .room_ok(room_ok),
    .last_burst(last_burst), .burst(burst), .mem_waitrequest(mem_waitrequest),
    .mem_readdatavalid(mem_readdatavalid), .mem_read(mem_read), .busy(busy),
    .accept(accept), .beat_en(beat_en), .done_set(done_set)
  );

  fbd_lane_steer #(.DATA_W(DATA_W), .ROW_WORDS(ROW_WORDS)) steer_i (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .beat_en(beat_en),
    .beat_data(mem_readdata), .cur_lane(cur_lane), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_lane(pix_lane)
  );

  assign mem_address    = ADDR_W'(addr);
  assign mem_burstcount = burst;

  // R5: request held unchanged while stalled
  assert_hold_on_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_read && mem_waitrequest) |=>
      (mem_read && $stable(mem_address) && $stable(mem_burstcount)));

  // R3: burst count presented is a legal power of two
  assert_burst_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read |-> (($countones(mem_burstcount) == 1) && (mem_burstcount <= BCW'(BURST_MAX))));

  // R9: forwarded words come only from valid returns during a run
  assert_fwd_from_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(mem_readdatavalid && busy));

endmodule

// File: tb/frame_burst_dma_tb_top.sv
module frame_burst_dma_tb_top;

  localparam int ROW = 320;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] mem_address;
  logic        mem_read;
  logic [2:0]  mem_burstcount;
  logic        mem_waitrequest = 1'b0;
  logic [31:0] mem_readdata = '0;
  logic        mem_readdatavalid = 1'b0;
  logic [11:0] lane0_room = 12'd1000;
  logic [11:0] lane1_room = 12'd1000;
  logic        pix_valid;
  logic [31:0] pix_data;
  logic        pix_lane;

  always #5 clk = ~clk;

  frame_burst_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_address(mem_address), .mem_read(mem_read),
    .mem_burstcount(mem_burstcount), .mem_waitrequest(mem_waitrequest),
    .mem_readdata(mem_readdata), .mem_readdatavalid(mem_readdatavalid),
    .lane0_room(lane0_room), .lane1_room(lane1_room), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_lane(pix_lane)
  );

  int checks = 0;
  int failures = 0;
  int delivered = 0;
  int cyc = 0;
  int wr_mode = 0;
  int force_wait = 0;
  int beats_left = 0;
  bit stray = 1'b0;
  bit prev_wait = 1'b0;
  bit prev_acc = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [2:0]  prev_bc = '0;
  logic [31:0] cur_addr = '0;
  logic [31:0] tag = '0;

  logic [31:0] exp_data[$];
  bit          exp_lane[$];
  logic [31:0] exp_addr[$];
  logic [2:0]  exp_bc[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (pix_valid) begin
      if (exp_data.size() == 0) begin
        chk(1'b0, "R9 unexpected word", pix_data, 32'hx);
      end else begin
        logic [31:0] d;
        bit l;
        d = exp_data.pop_front();
        l = exp_lane.pop_front();
        chk(pix_data == d, "R9 word data", pix_data, d);
        chk(pix_lane == l, "R10 word lane", {31'd0, pix_lane}, {31'd0, l});
        delivered++;
      end
    end
  end

  // memory model
  always @(negedge clk) begin
    bit wr;
    cyc++;
    if (prev_wait)
      chk(mem_read && mem_address == prev_addr && mem_burstcount == prev_bc,
          "R5 hold while stalled", mem_address, prev_addr);
    if (prev_acc)
      chk(!mem_read, "R5 read drops after accept", {31'd0, mem_read}, 32'd0);
    if (mem_read && beats_left > 0)
      chk(1'b0, "R7 read with beats outstanding", beats_left, 0);
    if (beats_left > 0 && (cyc % 5) != 3) begin
      mem_readdatavalid = 1'b1;
      mem_readdata = cur_addr ^ tag;
      cur_addr += 4;
      beats_left--;
    end else if (beats_left == 0 && stray) begin
      mem_readdatavalid = 1'b1;
      mem_readdata = 32'hDEAD_BEEF;
      stray = 1'b0;
    end else begin
      mem_readdatavalid = 1'b0;
    end
    if (force_wait > 0) begin
      wr = 1'b1;
      force_wait--;
    end else begin
      wr = (wr_mode == 1) && ((cyc % 7) < 2);
    end
    mem_waitrequest = wr;
    if (mem_read && !wr) begin
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R6 unexpected burst", mem_address, 32'hx);
      end else begin
        logic [31:0] ea;
        logic [2:0] eb;
        ea = exp_addr.pop_front();
        eb = exp_bc.pop_front();
        chk(mem_address == ea, "R6 burst address", mem_address, ea);
        chk(mem_burstcount == eb, "R6 burst count", {29'd0, mem_burstcount}, {29'd0, eb});
      end
      beats_left = int'(mem_burstcount);
      cur_addr = mem_address;
    end
    prev_wait = mem_read && wr;
    prev_acc  = mem_read && !wr;
    prev_addr = mem_address;
    prev_bc   = mem_burstcount;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic plan_run(input int frames, input int size, input int burst, input logic [31:0] t);
    int g = 0;
    tag = t;
    for (int f = 0; f < frames; f++) begin
      for (int a = 0; a < size; a += burst * 4) begin
        exp_addr.push_back(32'(a));
        exp_bc.push_back(3'(burst));
        for (int b = 0; b < burst; b++) begin
          exp_data.push_back(32'(a + 4 * b) ^ t);
          exp_lane.push_back(((g / ROW) % 2) == 1);
          g++;
        end
      end
    end
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s = '0;
    int n = 0;
    while (n < 20000 && s[0] == 1'b0) begin
      reg_rd(3'd4, s);
      n++;
    end
    chk(s == 32'd1, req, s, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(!mem_read && !pix_valid, "R1 outputs idle", {30'd0, mem_read, pix_valid}, 32'd0);
    reg_rd(3'd4, v); chk(v == 0, "R1 status", v, 0);
    reg_rd(3'd3, v); chk(v == 4, "R1 burst default", v, 4);
    reg_rd(3'd1, v); chk(v == 0, "R1 frames", v, 0);
    reg_rd(3'd2, v); chk(v == 0, "R1 size", v, 0);

    // R2 register map
    reg_wr(3'd1, 32'd2);
    reg_wr(3'd2, 32'd2560);
    reg_wr(3'd3, 32'd2);
    reg_rd(3'd1, v); chk(v == 2, "R2 frames readback", v, 2);
    reg_rd(3'd2, v); chk(v == 2560, "R2 size readback", v, 2560);
    reg_rd(3'd3, v); chk(v == 2, "R2 burst readback", v, 2);

    // R3 illegal burst lengths ignored
    reg_wr(3'd3, 32'd3); reg_rd(3'd3, v); chk(v == 2, "R3 value 3 ignored", v, 2);
    reg_wr(3'd3, 32'd0); reg_rd(3'd3, v); chk(v == 2, "R3 value 0 ignored", v, 2);
    reg_wr(3'd3, 32'd8); reg_rd(3'd3, v); chk(v == 2, "R3 value 8 ignored", v, 2);
    reg_wr(3'd3, 32'd4); reg_rd(3'd3, v); chk(v == 4, "R3 value 4 taken", v, 4);

    // R4 start with zero frames or tiny image ignored
    reg_wr(3'd1, 32'd0);
    reg_wr(3'd0, 32'd1);
    repeat (3) @(negedge clk);
    reg_rd(3'd4, v); chk(v == 0, "R4 start with zero frames", v, 0);
    reg_wr(3'd1, 32'd1);
    reg_wr(3'd2, 32'd8);
    reg_wr(3'd0, 32'd1);
    repeat (3) @(negedge clk);
    reg_rd(3'd0, v); chk(v == 0, "R4 start with image below one burst", v, 0);

    // R9 stray valid while idle
    stray = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!pix_valid, "R9 stray valid ignored", {31'd0, pix_valid}, 0);
    @(negedge clk);
    chk(!pix_valid, "R9 stray valid ignored", {31'd0, pix_valid}, 0);

    // Run 1: two frames of two rows, burst 4, stalls
    reg_wr(3'd1, 32'd2);
    reg_wr(3'd2, 32'd2560);
    plan_run(2, 2560, 4, 32'h1100_0000);
    wr_mode = 1;
    force_wait = 6;
    reg_wr(3'd0, 32'd1);
    reg_rd(3'd4, v); chk(v == 2, "R2 busy after start", v, 2);
    reg_wr(3'd1, 32'd7);   // R12: ignored while busy
    reg_wr(3'd3, 32'd1);   // R12: ignored while busy
    reg_wr(3'd0, 32'd1);   // R4: start while busy ignored
    wait_done("R11 run1 done");
    chk(exp_data.size() == 0 && exp_addr.size() == 0, "R6 run1 all words delivered",
        exp_data.size(), 0);
    reg_rd(3'd1, v); chk(v == 2, "R12 frames unchanged", v, 2);
    reg_rd(3'd3, v); chk(v == 4, "R12 burst unchanged", v, 4);
    repeat (20) @(negedge clk);
    chk(!mem_read, "R11 no read after done", {31'd0, mem_read}, 0);

    // Run 2: burst 1, three short frames; start clears done
    reg_wr(3'd3, 32'd1);
    reg_wr(3'd1, 32'd3);
    reg_wr(3'd2, 32'd64);
    plan_run(3, 64, 1, 32'h2200_0000);
    reg_wr(3'd0, 32'd1);
    reg_rd(3'd4, v); chk(v == 2, "R11 start clears done", v, 2);
    wait_done("R11 run2 done");
    chk(exp_data.size() == 0 && exp_addr.size() == 0, "R6 run2 all words delivered",
        exp_data.size(), 0);

    // Run 3: burst 2, lane 1 short of room
    wr_mode = 0;
    delivered = 0;
    lane1_room = 12'd1;
    reg_wr(3'd3, 32'd2);
    reg_wr(3'd1, 32'd1);
    reg_wr(3'd2, 32'd2560);
    plan_run(1, 2560, 2, 32'h3300_0000);
    reg_wr(3'd0, 32'd1);
    while (delivered < ROW) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(!mem_read && delivered == ROW, "R8 stall when room below burst", delivered, ROW);
    reg_rd(3'd0, v); chk(v == 1, "R8 still busy while stalled", v, 1);
    lane1_room = 12'd2;    // R8: equal room is enough
    wait_done("R8 run3 done with exact room");
    chk(exp_data.size() == 0 && delivered == 2 * ROW, "R10 both rows delivered",
        delivered, 2 * ROW);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule